// File: doc/BRIEF.md
# Dual-Section Registered Bus Transceiver

This block moves data between an A port and a B port in either direction. Its bus is split into independent sections, two sections of 8 bits by default. Each section has one isolate input, one direction input, and one source pick for each direction. Each section also has one storage register for each port. When a section drives, it can pass live data from the opposite port, or it can drive the value held in the register for that direction.

Port pins are modelled as separate input, output and output-enable vectors. A keeper register in each section holds the last value that the section drove onto each port. When the section stops driving a port, the port's output shows that held value. Registers load on a rising `clk` edge while their load strobe is high, whatever the isolate and direction inputs are. They load the resolved port value: the driven value when the block drives that port, and the external input value otherwise.

Top module: `dual_reg_transceiver`

## Requirements
- R1: Each section owns bits [s*SEC_W +: SEC_W] of every bus vector and its own bit s of every control vector, and responds only to its own controls.
- R2: While `iso[s]` is 1, section s asserts neither `a_oe` nor `b_oe` on any of its bits.
- R3: With `iso[s]`=0 and `dir_ab[s]`=1, section s sets all its `b_oe` bits and clears all its `a_oe` bits; with `pick_ab[s]`=0, `b_out` equals the live `a_in`.
- R4: With `iso[s]`=0 and `dir_ab[s]`=0, section s sets all its `a_oe` bits and clears all its `b_oe` bits; with `pick_ba[s]`=0, `a_out` equals the live `b_in`.
- R5: A pick value of 1 drives the stored register (the A register toward B, the B register toward A) instead of live data.
- R6: At a rising `clk` edge with `load_a[s]` (`load_b[s]`) high, the A (B) register of section s takes the resolved A (B) port value, whatever the isolate and direction inputs are.
- R7: Both registers of a section can load in the same cycle while the section is isolated.
- R8: When the section drives a port during a load, the register takes the driven value and ignores that port's input vector.
- R9: While a section does not drive a port, that port's output holds the last value the section drove there.
- R10: A synchronous active-high `rst` clears every storage register and every keeper value to zero.
- R11: No bit ever has `a_oe` and `b_oe` set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registers and keepers |
| rst | input | 1 | Synchronous reset, active high |
| iso | input | SECTIONS | 1 isolates a section: it drives neither port |
| dir_ab | input | SECTIONS | 1 drives B from A, 0 drives A from B |
| pick_ab | input | SECTIONS | Source toward B: 0 live A, 1 A register |
| pick_ba | input | SECTIONS | Source toward A: 0 live B, 1 B register |
| load_a | input | SECTIONS | Load strobe for the A register |
| load_b | input | SECTIONS | Load strobe for the B register |
| a_in | input | SECTIONS*SEC_W | External value seen on the A pins |
| a_out | output | SECTIONS*SEC_W | Value driven, or held, on the A pins |
| a_oe | output | SECTIONS*SEC_W | Per-bit A drive enable |
| b_in | input | SECTIONS*SEC_W | External value seen on the B pins |
| b_out | output | SECTIONS*SEC_W | Value driven, or held, on the B pins |
| b_oe | output | SECTIONS*SEC_W | Per-bit B drive enable |

## Verification
The bench builds the block with its defaults: two sections of 8 bits. With two sections, one vector can drive the sections in opposite directions, with different picks and isolate settings. This shows that each section's slice selects the correct bits. One such vector also loads a register half from driven data and half from external input. All sixteen isolate and direction combinations for the two sections are swept to check that the two drive enables never overlap. A reset in the middle of a run shows that the stored and held values return to zero.

// File: rtl/dual_reg_transceiver.sv
module dual_reg_transceiver #(
  parameter int SECTIONS = 2,
  parameter int SEC_W    = 8,
  localparam int N = SECTIONS * SEC_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SECTIONS-1:0] iso,
  input  logic [SECTIONS-1:0] dir_ab,
  input  logic [SECTIONS-1:0] pick_ab,
  input  logic [SECTIONS-1:0] pick_ba,
  input  logic [SECTIONS-1:0] load_a,
  input  logic [SECTIONS-1:0] load_b,
  input  logic [N-1:0]        a_in,
  output logic [N-1:0]        a_out,
  output logic [N-1:0]        a_oe,
  input  logic [N-1:0]        b_in,
  output logic [N-1:0]        b_out,
  output logic [N-1:0]        b_oe
);

  for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
    localparam int LO = s * SEC_W;

    logic [SEC_W-1:0] reg_a, reg_b, keep_a, keep_b;
    logic [SEC_W-1:0] drv_a, drv_b, res_a, res_b;
    logic             en_ab, en_ba;

    assign en_ab = !iso[s] && dir_ab[s];
    assign en_ba = !iso[s] && !dir_ab[s];

    assign drv_b = pick_ab[s] ? reg_a : a_in[LO +: SEC_W];
    assign drv_a = pick_ba[s] ? reg_b : b_in[LO +: SEC_W];

    assign res_a = en_ba ? drv_a : a_in[LO +: SEC_W];
    assign res_b = en_ab ? drv_b : b_in[LO +: SEC_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        reg_a  <= '0;
        reg_b  <= '0;
        keep_a <= '0;
        keep_b <= '0;
      end else begin
        if (load_a[s]) reg_a  <= res_a;
        if (load_b[s]) reg_b  <= res_b;
        if (en_ba)     keep_a <= drv_a;
        if (en_ab)     keep_b <= drv_b;
      end
    end

    assign a_out[LO +: SEC_W] = en_ba ? drv_a : keep_a;
    assign b_out[LO +: SEC_W] = en_ab ? drv_b : keep_b;
    assign a_oe[LO +: SEC_W]  = {SEC_W{en_ba}};
    assign b_oe[LO +: SEC_W]  = {SEC_W{en_ab}};

    // R11
    oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
      (a_oe[LO +: SEC_W] & b_oe[LO +: SEC_W]) == '0);

    // R2
    iso_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      iso[s] |-> (a_oe[LO +: SEC_W] == '0 && b_oe[LO +: SEC_W] == '0));

    // R9
    hold_a_chk: assert property (@(posedge clk) disable iff (rst)
      (!a_oe[LO] && !$past(a_oe[LO]) && !$past(rst)) |-> $stable(a_out[LO +: SEC_W]));

    // R9
    hold_b_chk: assert property (@(posedge clk) disable iff (rst)
      (!b_oe[LO] && !$past(b_oe[LO]) && !$past(rst)) |-> $stable(b_out[LO +: SEC_W]));

    // R6
    load_a_chk: assert property (@(posedge clk) disable iff (rst)
      load_a[s] |=> reg_a == $past(a_oe[LO] ? a_out[LO +: SEC_W] : a_in[LO +: SEC_W]));

    // R6
    load_b_chk: assert property (@(posedge clk) disable iff (rst)
      load_b[s] |=> reg_b == $past(b_oe[LO] ? b_out[LO +: SEC_W] : b_in[LO +: SEC_W]));

    // R10
    rst_clear_chk: assert property (@(posedge clk)
      rst |=> (reg_a == '0 && reg_b == '0 && keep_a == '0 && keep_b == '0));
  end

endmodule

// File: tb/test_dual_reg_transceiver.sv
module test_dual_reg_transceiver;
  localparam int S = 2;
  localparam int W = 8;
  localparam int N = S * W;
  localparam int NV = 9;

  logic clk = 0;
  logic rst = 1;
  logic [S-1:0] iso = '1, dir_ab = '0, pick_ab = '0, pick_ba = '0, load_a = '0, load_b = '0;
  logic [N-1:0] a_in = '0, b_in = '0;
  logic [N-1:0] a_out, a_oe, b_out, b_oe;
  int runs = 0, fails = 0;

  always #10 clk = ~clk;

  dual_reg_transceiver #(.SECTIONS(S), .SEC_W(W)) i_dual_reg_transceiver (
    .clk(clk), .rst(rst), .iso(iso), .dir_ab(dir_ab), .pick_ab(pick_ab),
    .pick_ba(pick_ba), .load_a(load_a), .load_b(load_b),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

  // {iso, dir_ab, pick_ab, pick_ba, load_a, load_b, a_in, b_in, a_oe, b_oe, a_out, b_out}
  localparam logic [107:0] TBL [0:NV-1] = '{
    {2'b11,2'b00,2'b00,2'b00,2'b11,2'b11,16'h1234,16'h5678,16'h0000,16'h0000,16'h0000,16'h0000},
    {2'b00,2'b11,2'b00,2'b00,2'b00,2'b00,16'hABCD,16'h0000,16'h0000,16'hFFFF,16'h0000,16'hABCD},
    {2'b00,2'b11,2'b11,2'b00,2'b00,2'b00,16'hFFFF,16'h0000,16'h0000,16'hFFFF,16'h0000,16'h1234},
    {2'b00,2'b00,2'b00,2'b00,2'b11,2'b00,16'h0000,16'h0F0F,16'hFFFF,16'h0000,16'h0F0F,16'h1234},
    {2'b00,2'b00,2'b00,2'b11,2'b00,2'b00,16'h0000,16'hFFFF,16'hFFFF,16'h0000,16'h5678,16'h1234},
    {2'b00,2'b01,2'b01,2'b00,2'b11,2'b11,16'h1111,16'h2222,16'hFF00,16'h00FF,16'h2278,16'h120F},
    {2'b10,2'b00,2'b00,2'b11,2'b00,2'b00,16'h0000,16'h0000,16'h00FF,16'h0000,16'h220F,16'h120F},
    {2'b00,2'b11,2'b11,2'b00,2'b00,2'b00,16'h0000,16'h0000,16'h0000,16'hFFFF,16'h220F,16'h2211},
    {2'b00,2'b00,2'b00,2'b11,2'b00,2'b00,16'h0000,16'h0000,16'hFFFF,16'h0000,16'h220F,16'h2211}
  };

  string vtag [0:NV-1] = '{"R2 R7 R10", "R3", "R5 R9", "R4 R8 R9", "R5",
                           "R1 R6 R8", "R1 R2 R9", "R5 R6", "R5 R6"};

  task automatic check(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(logic [107:0] v);
    {iso, dir_ab, pick_ab, pick_ba, load_a, load_b, a_in, b_in} = v[107:64];
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    #1;
    // R10: outputs after reset with everything isolated
    check("R10 a_out", a_out, '0);
    check("R10 b_out", b_out, '0);
    check("R2 a_oe", a_oe, '0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      #1;
      check({vtag[i], " a_oe"},  a_oe,  TBL[i][63:48]);
      check({vtag[i], " b_oe"},  b_oe,  TBL[i][47:32]);
      check({vtag[i], " a_out"}, a_out, TBL[i][31:16]);
      check({vtag[i], " b_out"}, b_out, TBL[i][15:0]);
    end

    // R11: sweep isolate and direction for both sections
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      {iso, dir_ab} = c[3:0];
      load_a = '0; load_b = '0;
      #1;
      check("R11 overlap", a_oe & b_oe, '0);
    end

    // R10: reset in mid-run clears stored and held values
    @(negedge clk);
    rst = 1; iso = '1;
    @(negedge clk);
    rst = 0;
    #1;
    check("R10 held a_out", a_out, '0);
    check("R10 held b_out", b_out, '0);
    @(negedge clk);
    iso = '0; dir_ab = '1; pick_ab = '1;
    #1;
    check("R10 A register", b_out, '0);
    @(negedge clk);
    dir_ab = '0; pick_ba = '1;
    #1;
    check("R10 B register", a_out, '0);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule